// File: doc/BRIEF.md
# Adapter Command and Interrupt-Status Controller

This block sits between a host bus and the datapath of a network adapter. The host writes 16-bit command words to one port. The top five bits of each word select an operation and the low eleven bits carry its argument. The block decodes each accepted command into a one-cycle pulse for the neighbouring blocks. It also keeps the state that belongs to the control path: the selected register window, the receiver enable, an interrupt mask and a read-zero mask.

Event pulses from the datapath set latched cause bits. The host clears these bits with an acknowledge command whose argument is a bit mask. A summary latch bit sets whenever a cause enabled by the interrupt mask is raised. The interrupt line follows that latch and the enabled causes. A host read strobe captures a status word that holds the window number, a command-busy flag and the visible cause bits. Reset-type commands hold the busy flag for a fixed number of cycles, and commands written during that time are dropped.

Top module: `host_ctl_unit`

## Requirements
- R1: An accepted command word sets bit `op` of `cmd_pulse` for exactly one cycle, starting the cycle after the write, where `op` = word[15:11]. `cmd_arg` takes word[10:0] at the same time and holds it until the next accepted command.
- R2: Opcode 1 loads the window number from argument bits 2:0. `win_sel` changes only on an accepted opcode 1 or a global reset.
- R3: When `stat_re` is high, `stat_rdata` is loaded at that edge with {window[15:13], busy[12], 4'b0000[11:8], visible causes[7:0]}, using the state before the edge. `stat_rdata` holds between reads.
- R4: Cause bit positions are: 1 adapter failure, 2 tx complete, 3 tx available, 4 rx complete, 5 rx early, 6 interrupt requested, 7 statistics update. Each event pulse sets its bit, and opcode 12 sets bit 6.
- R5: Opcode 13 clears each cause bit 7:0 whose argument bit is 1. If an event for the same bit arrives in the same cycle, the bit stays set.
- R6: Latch bit 0 sets in any cycle where a cause event arrives whose mask bit (loaded from argument bits 7:1 by opcode 14) is 1. `irq` is high when bit 0 is set and at least one set cause in 7:1 is enabled by the interrupt mask.
- R7: Opcode 15 loads the read-zero mask from argument bits 7:0. A cause bit whose mask bit is 0 reads as 0 in the status word but stays latched, and it shows again when its mask bit is set.
- R8: The receiver is disabled after reset. Opcode 4 enables it (`rx_enabled`=1) and opcode 3 disables it.
- R9: Opcodes 0, 5 and 11 make the block busy for BUSY_CYCLES cycles. A command written while busy changes no state and produces no pulse.
- R10: Opcode 0 (global reset) clears all cause bits and the interrupt mask, sets the read-zero mask to all ones, sets the window to 0 and disables the receiver.
- R11: After rst_n the status word is 0x0000, `irq` is 0, the window is 0 and the read-zero mask is all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_we | input | 1 | Command write strobe |
| cmd_wdata | input | 16 | Command word: opcode 15:11, argument 10:0 |
| stat_re | input | 1 | Status read strobe |
| ev_fail | input | 1 | Adapter failure event pulse |
| ev_tx_done | input | 1 | Transmit complete event pulse |
| ev_tx_avail | input | 1 | Transmit space available event pulse |
| ev_rx_done | input | 1 | Receive complete event pulse |
| ev_rx_early | input | 1 | Receive early threshold event pulse |
| ev_stats | input | 1 | Statistics update event pulse |
| stat_rdata | output | 16 | Status word captured on read |
| irq | output | 1 | Interrupt request line |
| win_sel | output | 3 | Selected register window |
| rx_enabled | output | 1 | Receiver enable level |
| cmd_pulse | output | 32 | One-hot decoded command pulse, indexed by opcode |
| cmd_arg | output | 11 | Argument of the last accepted command |

## Verification
An acknowledge command and a datapath event can hit the same cause bit in the same cycle. The bench forces this in a directed case: a tx-complete pulse arrives while an acknowledge clears that bit and the latch bit. It then reads the status back and checks that both bits survive and that `irq` stays high. The random phase drives events and acknowledges together in many cycles, and a bench model that applies the event-over-acknowledge rule compares the status word and `irq` after every cycle. A reset-type command followed at once by a window write also checks that the busy window drops the second command.

// File: rtl/hcu_pkg.sv
// Shared widths, opcodes and cause bit positions for the command/status controller.
package hcu_pkg;
    localparam int CMD_W   = 16;
    localparam int OP_W    = 5;
    localparam int ARG_W   = CMD_W - OP_W;
    localparam int NUM_OPS = 1 << OP_W;
    localparam int CAUSE_W = 8;
    localparam int WIN_W   = 3;

    typedef enum logic [OP_W-1:0] {
        OP_GLOBAL_RST  = 5'd0,
        OP_SEL_WINDOW  = 5'd1,
        OP_RX_OFF      = 5'd3,
        OP_RX_ON       = 5'd4,
        OP_RX_RST      = 5'd5,
        OP_TX_RST      = 5'd11,
        OP_INT_REQ     = 5'd12,
        OP_ACK         = 5'd13,
        OP_LOAD_IMASK  = 5'd14,
        OP_LOAD_RDMASK = 5'd15
    } op_e;

    localparam int C_LATCH   = 0;
    localparam int C_FAIL    = 1;
    localparam int C_TXDONE  = 2;
    localparam int C_TXAVAIL = 3;
    localparam int C_RXDONE  = 4;
    localparam int C_RXEARLY = 5;
    localparam int C_INTREQ  = 6;
    localparam int C_STATS   = 7;
endpackage

// File: rtl/hcu_cmd_decode.sv
// Splits a command word into opcode and argument, gates it with the busy flag
// and registers a one-hot pulse per opcode plus the argument.
// Assumes: cmd_we is a single-cycle strobe; busy comes from the busy timer.
module hcu_cmd_decode
    import hcu_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cmd_we,
    input  logic [CMD_W-1:0]   cmd_wdata,
    input  logic               busy,
    output logic               accept,
    output logic [OP_W-1:0]    op,
    output logic [ARG_W-1:0]   arg,
    output logic               is_reset_cmd,
    output logic [NUM_OPS-1:0] pulse_q,
    output logic [ARG_W-1:0]   arg_q
);
    logic [NUM_OPS-1:0] pulse_d;

    assign op     = cmd_wdata[CMD_W-1 -: OP_W];
    assign arg    = cmd_wdata[ARG_W-1:0];
    assign accept = cmd_we & ~busy;
    assign is_reset_cmd = accept &
        ((op == OP_GLOBAL_RST) || (op == OP_RX_RST) || (op == OP_TX_RST));

    // One decode term per opcode
    for (genvar g = 0; g < NUM_OPS; g++) begin : g_dec
        assign pulse_d[g] = accept && (op == OP_W'(g));
    end

    // Register the pulses so each lasts one cycle
    always_ff @(posedge clk) begin
        if (!rst_n) pulse_q <= '0;
        else        pulse_q <= pulse_d;
    end

    // Keep the argument of the last accepted command
    always_ff @(posedge clk) begin
        if (!rst_n)      arg_q <= '0;
        else if (accept) arg_q <= arg;
    end
endmodule

// File: rtl/hcu_busy_timer.sv
// Down-counter that holds a busy flag for BUSY_CYCLES cycles after a load.
// Assumes: load is never raised while busy (the decoder gates it).
module hcu_busy_timer #(
    parameter int BUSY_CYCLES = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    output logic busy
);
    localparam int CNT_W = $clog2(BUSY_CYCLES + 1);

    logic [CNT_W-1:0] cnt_q;

    // Load on a reset-type command, otherwise count down to zero
    always_ff @(posedge clk) begin
        if (!rst_n)            cnt_q <= '0;
        else if (load)         cnt_q <= CNT_W'(BUSY_CYCLES);
        else if (cnt_q != '0)  cnt_q <= cnt_q - CNT_W'(1);
    end

    assign busy = (cnt_q != '0);
endmodule

// File: rtl/hcu_cause_reg.sv
// Latched interrupt-cause bits with acknowledge-by-mask, a summary latch bit
// and the interrupt line. An event beats an acknowledge of the same bit.
// Assumes: set_ev bits are single-cycle pulses; clear_all is a global reset.
module hcu_cause_reg
    import hcu_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clear_all,
    input  logic [CAUSE_W-1:1] set_ev,
    input  logic [CAUSE_W-1:0] ack,
    input  logic [CAUSE_W-1:1] imask,
    output logic [CAUSE_W-1:0] cause_q,
    output logic               irq
);
    logic [CAUSE_W-1:0] cause_d;

    // Per-bit next state: keep unless acknowledged, event sets
    for (genvar g = 1; g < CAUSE_W; g++) begin : g_bit
        assign cause_d[g] = (cause_q[g] & ~ack[g]) | set_ev[g];
    end
    assign cause_d[C_LATCH] = (cause_q[C_LATCH] & ~ack[C_LATCH]) | (|(set_ev & imask));

    // Cause storage
    always_ff @(posedge clk) begin
        if (!rst_n || clear_all) cause_q <= '0;
        else                     cause_q <= cause_d;
    end

    assign irq = cause_q[C_LATCH] & (|(cause_q[CAUSE_W-1:1] & imask));
endmodule

// File: rtl/host_ctl_unit.sv
// Top of the command/status controller: decodes host command words, keeps
// window, masks and receiver enable, latches causes and builds the status word.
// Assumes: synchronous active-low reset; host strobes are single-cycle.
module host_ctl_unit
    import hcu_pkg::*;
#(
    parameter int BUSY_CYCLES = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cmd_we,
    input  logic [15:0]        cmd_wdata,
    input  logic               stat_re,
    input  logic               ev_fail,
    input  logic               ev_tx_done,
    input  logic               ev_tx_avail,
    input  logic               ev_rx_done,
    input  logic               ev_rx_early,
    input  logic               ev_stats,
    output logic [15:0]        stat_rdata,
    output logic               irq,
    output logic [2:0]         win_sel,
    output logic               rx_enabled,
    output logic [31:0]        cmd_pulse,
    output logic [10:0]        cmd_arg
);
    logic               busy;
    logic               accept;
    logic [OP_W-1:0]    op;
    logic [ARG_W-1:0]   arg;
    logic               is_reset_cmd;
    logic               glob;
    logic [WIN_W-1:0]   win_q;
    logic [CAUSE_W-1:0] imask_q;
    logic [CAUSE_W-1:0] rdmask_q;
    logic               rx_en_q;
    logic [CAUSE_W-1:1] set_ev;
    logic [CAUSE_W-1:0] ack;
    logic [CAUSE_W-1:0] cause_q;
    logic [CMD_W-1:0]   status_now;

    hcu_cmd_decode u_dec (
        .clk          (clk),
        .rst_n        (rst_n),
        .cmd_we       (cmd_we),
        .cmd_wdata    (cmd_wdata),
        .busy         (busy),
        .accept       (accept),
        .op           (op),
        .arg          (arg),
        .is_reset_cmd (is_reset_cmd),
        .pulse_q      (cmd_pulse),
        .arg_q        (cmd_arg)
    );

    hcu_busy_timer #(.BUSY_CYCLES(BUSY_CYCLES)) u_busy (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (is_reset_cmd),
        .busy  (busy)
    );

    assign glob = accept && (op == OP_GLOBAL_RST);

    // Cause sources in bit order 7..1
    assign set_ev = {ev_stats, accept && (op == OP_INT_REQ), ev_rx_early,
                     ev_rx_done, ev_tx_avail, ev_tx_done, ev_fail};
    assign ack = (accept && (op == OP_ACK)) ? arg[CAUSE_W-1:0] : '0;

    hcu_cause_reg u_cause (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear_all (glob),
        .set_ev    (set_ev),
        .ack       (ack),
        .imask     (imask_q[CAUSE_W-1:1]),
        .cause_q   (cause_q),
        .irq       (irq)
    );

    // Window, masks and receiver enable, all restored by a global reset
    always_ff @(posedge clk) begin
        if (!rst_n || glob) begin
            win_q    <= '0;
            imask_q  <= '0;
            rdmask_q <= '1;
            rx_en_q  <= 1'b0;
        end else if (accept) begin
            case (op)
                OP_SEL_WINDOW:  win_q    <= arg[WIN_W-1:0];
                OP_LOAD_IMASK:  imask_q  <= arg[CAUSE_W-1:0];
                OP_LOAD_RDMASK: rdmask_q <= arg[CAUSE_W-1:0];
                OP_RX_ON:       rx_en_q  <= 1'b1;
                OP_RX_OFF:      rx_en_q  <= 1'b0;
                default: ;
            endcase
        end
    end

    assign status_now = {win_q, busy, 4'b0000, cause_q & rdmask_q};

    // Capture the status word on a host read
    always_ff @(posedge clk) begin
        if (!rst_n)       stat_rdata <= '0;
        else if (stat_re) stat_rdata <= status_now;
    end

    assign win_sel    = win_q;
    assign rx_enabled = rx_en_q;
endmodule

// File: rtl/hcu_checker.sv
// Property checker for host_ctl_unit, attached by bind below.
module hcu_checker
    import hcu_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        cmd_we,
    input logic [15:0] cmd_wdata,
    input logic        ev_tx_done,
    input logic [15:0] stat_rdata,
    input logic        irq,
    input logic [2:0]  win_sel,
    input logic        rx_enabled,
    input logic [31:0] cmd_pulse,
    input logic        busy,
    input logic [7:0]  cause
);
    logic glob_acc;
    assign glob_acc = cmd_we && !busy && (cmd_wdata[15:11] == 5'd0);

    a_r1_pulse_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(cmd_pulse));

    a_r2_window_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_we |=> $stable(win_sel));

    a_r3_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        stat_rdata[11:8] == 4'b0000);

    a_r5_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_tx_done && !glob_acc) |=> cause[C_TXDONE]);

    a_r6_irq_needs_latch: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> cause[C_LATCH]);

    a_r9_ignore_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cmd_we) |=> (cmd_pulse == 32'd0));

    a_r10_global_clear: assert property (@(posedge clk) disable iff (!rst_n)
        glob_acc |=> (win_sel == 3'd0) && !rx_enabled && (cause == 8'd0));
endmodule

bind host_ctl_unit hcu_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_we     (cmd_we),
    .cmd_wdata  (cmd_wdata),
    .ev_tx_done (ev_tx_done),
    .stat_rdata (stat_rdata),
    .irq        (irq),
    .win_sel    (win_sel),
    .rx_enabled (rx_enabled),
    .cmd_pulse  (cmd_pulse),
    .busy       (busy),
    .cause      (cause_q)
);

// File: tb/sim_host_ctl_unit.sv
`timescale 1ns/1ps
module sim_host_ctl_unit;
    localparam int BUSY = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_we = 1'b0;
    logic [15:0] cmd_wdata = '0;
    logic        stat_re = 1'b0;
    logic [5:0]  ev = '0;   // {stats, rx_early, rx_done, tx_avail, tx_done, fail}
    logic [15:0] stat_rdata;
    logic        irq;
    logic [2:0]  win_sel;
    logic        rx_enabled;
    logic [31:0] cmd_pulse;
    logic [10:0] cmd_arg;

    int n_chk = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    host_ctl_unit #(.BUSY_CYCLES(BUSY)) u0 (
        .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd_wdata(cmd_wdata),
        .stat_re(stat_re), .ev_fail(ev[0]), .ev_tx_done(ev[1]),
        .ev_tx_avail(ev[2]), .ev_rx_done(ev[3]), .ev_rx_early(ev[4]),
        .ev_stats(ev[5]), .stat_rdata(stat_rdata), .irq(irq),
        .win_sel(win_sel), .rx_enabled(rx_enabled), .cmd_pulse(cmd_pulse),
        .cmd_arg(cmd_arg)
    );

    // Bench model state
    logic [2:0]  m_win;
    int          m_cnt;
    logic [7:0]  m_cause, m_imask, m_rdmask;
    logic        m_rx;
    logic [31:0] m_pulse;
    logic [10:0] m_arg;
    logic [15:0] m_rdata;

    function automatic logic m_irq();
        return m_cause[0] & (|(m_cause[7:1] & m_imask[7:1]));
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        m_win = 0; m_cnt = 0; m_cause = 0; m_imask = 0; m_rdmask = 8'hFF;
        m_rx = 0; m_pulse = 0; m_arg = 0; m_rdata = 0;
    endtask

    // Apply the inputs to the model as the design sees them at one edge
    task automatic model_edge(input logic we, input logic [15:0] d,
                              input logic [5:0] e, input logic re);
        logic busy_now, acc;
        logic [4:0] op;
        logic [10:0] a;
        logic [7:1] setv;
        logic [7:0] ackv;
        busy_now = (m_cnt != 0);
        acc = we && !busy_now;
        op = d[15:11];
        a = d[10:0];
        if (re) m_rdata = {m_win, busy_now, 4'b0000, m_cause & m_rdmask};
        m_pulse = acc ? (32'd1 << op) : 32'd0;
        if (acc) m_arg = a;
        if (acc && (op == 5'd0 || op == 5'd5 || op == 5'd11)) m_cnt = BUSY;
        else if (m_cnt != 0) m_cnt = m_cnt - 1;
        if (acc && op == 5'd0) begin
            m_win = 0; m_cause = 0; m_imask = 0; m_rdmask = 8'hFF; m_rx = 0;
        end else begin
            setv = {e[5], acc && op == 5'd12, e[4], e[3], e[2], e[1], e[0]};
            ackv = (acc && op == 5'd13) ? a[7:0] : 8'd0;
            m_cause[0] = (m_cause[0] & ~ackv[0]) | (|(setv & m_imask[7:1]));
            m_cause[7:1] = (m_cause[7:1] & ~ackv[7:1]) | setv;
            if (acc) begin
                case (op)
                    5'd1:  m_win = a[2:0];
                    5'd14: m_imask = a[7:0];
                    5'd15: m_rdmask = a[7:0];
                    5'd4:  m_rx = 1'b1;
                    5'd3:  m_rx = 1'b0;
                    default: ;
                endcase
            end
        end
    endtask

    // One cycle: drive at the falling edge, model at the rising edge, compare after
    task automatic step(input logic we, input logic [15:0] d,
                        input logic [5:0] e, input logic re);
        cmd_we = we; cmd_wdata = d; ev = e; stat_re = re;
        @(posedge clk);
        model_edge(we, d, e, re);
        @(negedge clk);
        cmd_we = 0; ev = 0; stat_re = 0;
        chk("R1 cmd_pulse", cmd_pulse, m_pulse);
        chk("R1 cmd_arg", 32'(cmd_arg), 32'(m_arg));
        chk("R2 win_sel", 32'(win_sel), 32'(m_win));
        chk("R3 stat_rdata", 32'(stat_rdata), 32'(m_rdata));
        chk("R6 irq", 32'(irq), 32'(m_irq()));
        chk("R8 rx_enabled", 32'(rx_enabled), 32'(m_rx));
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(0, 16'h0, 6'h0, 0);
    endtask

    task automatic rd();
        step(0, 16'h0, 6'h0, 1);
    endtask

    function automatic logic [4:0] pick_op(input int r);
        case (r)
            0: return 5'd0;   1: return 5'd1;   2: return 5'd1;   3: return 5'd3;
            4: return 5'd4;   5: return 5'd5;   6: return 5'd8;   7: return 5'd9;
            8: return 5'd11;  9: return 5'd12;  10: return 5'd13; 11: return 5'd13;
            12: return 5'd14; 13: return 5'd15; 14: return 5'd2;  default: return 5'd10;
        endcase
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        model_reset();
        rst_n = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;

        // R11: reset state
        rd();
        chk("R11 status after reset", 32'(stat_rdata), 32'h0);
        chk("R11 irq after reset", 32'(irq), 32'h0);
        chk("R11 rx after reset", 32'(rx_enabled), 32'h0);

        // R1: decoded pulse and argument for opcode 9
        step(1, 16'h4800 | 16'h0123, 6'h0, 0);
        chk("R1 pulse op9", cmd_pulse, 32'h200);
        chk("R1 arg op9", 32'(cmd_arg), 32'h123);
        idle(1);
        chk("R1 pulse one cycle", cmd_pulse, 32'h0);

        // R2: window select
        step(1, 16'h0805, 6'h0, 0);
        rd();
        chk("R2 window in status", 32'(stat_rdata[15:13]), 32'd5);

        // R8: receiver enable
        step(1, 16'h2000, 6'h0, 0);
        chk("R8 rx on", 32'(rx_enabled), 32'd1);

        // R4: tx complete sets bit 2, latch stays clear with mask empty
        step(0, 16'h0, 6'b000010, 0);
        rd();
        chk("R4 tx complete cause", 32'(stat_rdata), 32'hA004);
        chk("R4 no irq unmasked", 32'(irq), 32'd0);

        // R6: enabled cause raises latch and irq
        step(1, 16'h7004, 6'h0, 0);
        step(0, 16'h0, 6'b000010, 0);
        chk("R6 irq raised", 32'(irq), 32'd1);

        // R5: acknowledge and event of the same bit in one cycle
        step(1, 16'h6805, 6'b000010, 0);
        rd();
        chk("R5 event beats ack", 32'(stat_rdata[2:0]), 32'b101);
        chk("R5 irq kept", 32'(irq), 32'd1);
        step(1, 16'h6805, 6'h0, 0);
        chk("R5 ack clears irq", 32'(irq), 32'd0);

        // R7: read-zero mask hides but keeps a cause
        step(1, 16'h7800, 6'h0, 0);
        step(0, 16'h0, 6'b001000, 0);
        rd();
        chk("R7 hidden cause", 32'(stat_rdata[7:0]), 32'h0);
        step(1, 16'h78FF, 6'h0, 0);
        rd();
        chk("R7 cause kept", 32'(stat_rdata[4]), 32'd1);

        // R9: busy after tx reset, command dropped
        step(1, 16'h5800, 6'h0, 0);
        step(1, 16'h0803, 6'h0, 0);
        chk("R9 no pulse while busy", cmd_pulse, 32'h0);
        rd();
        chk("R9 busy flag", 32'(stat_rdata[12]), 32'd1);
        chk("R9 window unchanged", 32'(win_sel), 32'd5);
        idle(BUSY);
        step(1, 16'h0803, 6'h0, 0);
        chk("R9 accepted after busy", 32'(win_sel), 32'd3);

        // R10: global reset
        step(1, 16'h0000, 6'h0, 0);
        chk("R10 window cleared", 32'(win_sel), 32'd0);
        chk("R10 rx cleared", 32'(rx_enabled), 32'd0);
        idle(BUSY);
        rd();
        chk("R10 status cleared", 32'(stat_rdata), 32'h0);
        step(0, 16'h0, 6'b000010, 0);
        chk("R10 imask cleared", 32'(irq), 32'd0);

        // Random mix checked against the model each cycle
        for (int i = 0; i < 4000; i++) begin
            logic we;
            logic [15:0] d;
            logic [5:0] e;
            we = 1'($urandom);
            d = {pick_op(int'($urandom % 16)), 11'($urandom)};
            e = 6'($urandom) & 6'($urandom);
            step(we, d, e, 1'($urandom));
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule